// File: doc/BRIEF.md
# Dual-Port X/Y Data Memory

This block is the data memory of a DSP-style core. It places a register region, an X RAM bank and a Y RAM bank into one linear 16-bit byte-address space. Storage is 16 bits wide, with the low byte at the even address. The X port can read and write. The Y port only reads.

In ordinary mode the X port alone reaches every region, Y bank included. In multiply-accumulate mode the Y port reads the Y bank while the X port reads the rest of the space in the same cycle. In that mode, X-port reads that land in the Y bank are refused, but X-port writes still land there. The register region is not held here: it is forwarded to a passthrough port. The upper half of the space is a window onto program memory. A stub read port serves that window, and a control input enables it. Accesses that reach no storage return zero and raise a one-cycle error flag on the port concerned.

Top module: `xy_data_mem`

## Requirements
- R1: An X access to 0x0000–0x07FF drives `reg_req` in the same cycle. `reg_we` equals `x_we`, and `reg_waddr` equals `x_addr[10:1]`. For a read, the value on `reg_rdata` in the request cycle appears on `x_rdata` one cycle later.
- R2: X RAM is 0x0800–0x09FF and Y RAM is 0x0A00–0x0BFF. Both hold 16-bit words indexed by `addr[8:1]`, and address bit 0 is ignored. On a write, `x_be[0]` enables bits 7:0 and `x_be[1]` enables bits 15:8.
- R3: With `mac_mode` low, an X read or write in 0x0A00–0x0BFF reaches the Y RAM.
- R4: With `mac_mode` high, an X read in 0x0A00–0x0BFF returns 0x0000 with `x_err` high on the next cycle. An X write in that range still updates the Y RAM.
- R5: With `mac_mode` high, a Y read in 0x0A00–0x0BFF returns the Y RAM word on `y_rdata` one cycle later, alongside any X access. If the X port writes the same word in that cycle, the Y port returns the old contents.
- R6: A Y read with `mac_mode` low, or outside 0x0A00–0x0BFF, reads nothing. `y_rdata` is 0x0000 and `y_err` is high on the next cycle.
- R7: Any X access to 0x0C00–0x7FFF returns 0x0000 with `x_err` high on the next cycle. An X write there changes no storage.
- R8: With `prog_win_en` high, an X read at 0x8000 or above drives `prog_req` with `prog_waddr = x_addr[14:1]`, and `prog_rdata` appears on `x_rdata` one cycle later. In the following cases the access is treated as in R7 and `prog_req` stays low:
  - an X write at 0x8000 or above;
  - any X access at 0x8000 or above while `prog_win_en` is low.
- R9: Read data and error flags are valid for exactly the cycle after the request. After a cycle with no read (or an X write), `x_rdata`/`y_rdata` are 0x0000. After a cycle with no request, the matching error flag is low.
- R10: While reset is held, and in the first cycle after its release, `x_rdata`, `y_rdata`, `x_err` and `y_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mac_mode | input | 1 | Multiply-accumulate mode: Y bank split from X reads |
| prog_win_en | input | 1 | Enables the program-memory window at 0x8000 and above |
| x_req | input | 1 | X port access request |
| x_we | input | 1 | X port write (1) or read (0) |
| x_addr | input | 16 | X port byte address |
| x_be | input | 2 | X port byte enables for writes |
| x_wdata | input | 16 | X port write data |
| x_rdata | output | 16 | X port read data, one cycle after the request |
| x_err | output | 1 | X port error pulse |
| y_req | input | 1 | Y port read request |
| y_addr | input | 16 | Y port byte address |
| y_rdata | output | 16 | Y port read data, one cycle after the request |
| y_err | output | 1 | Y port error pulse |
| reg_req | output | 1 | Register-region access strobe |
| reg_we | output | 1 | Register-region write |
| reg_waddr | output | 10 | Register-region word address |
| reg_be | output | 2 | Register-region byte enables |
| reg_wdata | output | 16 | Register-region write data |
| reg_rdata | input | 16 | Register-region read data, valid in the request cycle |
| prog_req | output | 1 | Program-window read strobe |
| prog_waddr | output | 14 | Program-window word address |
| prog_rdata | input | 16 | Program-window read data, valid in the request cycle |

## Verification
The embedded properties watch the following on every cycle:
- error responses always carry zero data;
- a Y request outside multiply-accumulate mode is always flagged;
- a mode-split X read of the Y bank is always refused;
- the register strobe never fires outside its region;
- the program strobe stays low while the window is off;
- an idle X cycle leaves the outputs quiet.

The bench alone can show that storage holds the right contents after byte-enabled writes. It also shows that writes to unimplemented space leave the banks untouched, and that a concurrent Y read returns old data while the X port writes that word. It does so by comparing every read against its own model of both banks.

// File: rtl/xy_mem_pkg.sv
// Shared widths and region encoding for the X/Y data memory.
// Assumes a 16-bit byte-addressed space built from 16-bit words.
package xy_mem_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int BE_W   = DATA_W / 8;

    // Target region an access resolves to; RG_NONE means no storage.
    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_REG  = 3'd1,
        RG_XRAM = 3'd2,
        RG_YRAM = 3'd3,
        RG_PROG = 3'd4
    } region_e;
endpackage

// File: rtl/xy_addr_decode.sv
// Address decoder for one port of the X/Y data memory.
// First classifies the address into a base region, then applies port policy:
// the X variant refuses Y-bank reads in MAC mode and writes to the program
// window; the Y variant accepts only Y-bank reads in MAC mode.
// Assumes the RAM banks are contiguous and aligned to their sizes.
module xy_addr_decode
    import xy_mem_pkg::*;
#(
    parameter int REG_BYTES  = 2048,
    parameter int XRAM_BASE  = 'h0800,
    parameter int XRAM_BYTES = 512,
    parameter int YRAM_BYTES = 512,
    parameter int PROG_BASE  = 'h8000,
    parameter bit IS_Y_PORT  = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mac_mode,
    input  logic              is_write,
    input  logic              prog_en,
    output region_e           region
);
    localparam int YRAM_BASE = XRAM_BASE + XRAM_BYTES;
    localparam int RAM_END   = YRAM_BASE + YRAM_BYTES;

    logic [31:0] addr_w;
    region_e     base;

    // Widen the address for comparison against integer bounds.
    assign addr_w = 32'(addr);

    // Classify the address by region, independent of mode.
    always_comb begin
        if (addr_w < 32'(REG_BYTES))
            base = RG_REG;
        else if (addr_w >= 32'(XRAM_BASE) && addr_w < 32'(YRAM_BASE))
            base = RG_XRAM;
        else if (addr_w >= 32'(YRAM_BASE) && addr_w < 32'(RAM_END))
            base = RG_YRAM;
        else if (addr_w >= 32'(PROG_BASE) && prog_en)
            base = RG_PROG;
        else
            base = RG_NONE;
    end

    generate
        if (IS_Y_PORT) begin : g_ypol
            // Y port: read-only access to the Y bank in MAC mode only.
            always_comb begin
                region = (mac_mode && !is_write && base == RG_YRAM) ? RG_YRAM : RG_NONE;
            end
        end else begin : g_xpol
            // X port: carve Y reads out in MAC mode, program window is read-only.
            always_comb begin
                region = base;
                if (base == RG_YRAM && mac_mode && !is_write)
                    region = RG_NONE;
                if (base == RG_PROG && is_write)
                    region = RG_NONE;
            end
        end
    endgenerate
endmodule

// File: rtl/xy_ram_bank.sv
// Word RAM bank with one byte-enabled write port and N_RD registered read ports.
// A read and a write of the same word in one cycle return the old contents.
// Contents are not reset; only the read registers are.
module xy_ram_bank
    import xy_mem_pkg::*;
#(
    parameter int WORDS = 256,
    parameter int N_RD  = 1,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [BE_W-1:0]               wr_be,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [N_RD-1:0]               rd_en,
    input  logic [N_RD-1:0][IDX_W-1:0]    rd_idx,
    output logic [N_RD-1:0][DATA_W-1:0]   rd_data
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rd_q [N_RD];

    // Byte-enabled word write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b])
                    mem[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    generate
        for (genvar g = 0; g < N_RD; g++) begin : g_rd
            // Registered read for port g; holds when not enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rd_q[g] <= '0;
                else if (rd_en[g])
                    rd_q[g] <= mem[rd_idx[g]];
            end
            assign rd_data[g] = rd_q[g];
        end
    endgenerate
endmodule

// File: rtl/xy_data_mem.sv
// Dual-port X/Y data memory: register passthrough, X RAM, Y RAM and an
// optional program-memory window in one 16-bit byte address space.
// X port reads/writes everything in normal mode; in MAC mode X reads of the
// Y bank are refused while the Y port reads that bank concurrently.
// Assumes reg_rdata/prog_rdata are valid combinationally in the request cycle.
module xy_data_mem
    import xy_mem_pkg::*;
#(
    parameter int REG_BYTES  = 2048,
    parameter int XRAM_BASE  = 'h0800,
    parameter int XRAM_BYTES = 512,
    parameter int YRAM_BYTES = 512,
    parameter int PROG_BASE  = 'h8000,
    localparam int REG_AW    = $clog2(REG_BYTES),
    localparam int PROG_AW   = $clog2((1 << ADDR_W) - PROG_BASE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mac_mode,
    input  logic                 prog_win_en,
    input  logic                 x_req,
    input  logic                 x_we,
    input  logic [ADDR_W-1:0]    x_addr,
    input  logic [BE_W-1:0]      x_be,
    input  logic [DATA_W-1:0]    x_wdata,
    output logic [DATA_W-1:0]    x_rdata,
    output logic                 x_err,
    input  logic                 y_req,
    input  logic [ADDR_W-1:0]    y_addr,
    output logic [DATA_W-1:0]    y_rdata,
    output logic                 y_err,
    output logic                 reg_req,
    output logic                 reg_we,
    output logic [REG_AW-2:0]    reg_waddr,
    output logic [BE_W-1:0]      reg_be,
    output logic [DATA_W-1:0]    reg_wdata,
    input  logic [DATA_W-1:0]    reg_rdata,
    output logic                 prog_req,
    output logic [PROG_AW-2:0]   prog_waddr,
    input  logic [DATA_W-1:0]    prog_rdata
);
    localparam int YRAM_BASE = XRAM_BASE + XRAM_BYTES;
    localparam int RAM_END   = YRAM_BASE + YRAM_BYTES;
    localparam int XR_AW     = $clog2(XRAM_BYTES);
    localparam int YR_AW     = $clog2(YRAM_BYTES);
    localparam int XWORDS    = XRAM_BYTES / BE_W;
    localparam int YWORDS    = YRAM_BYTES / BE_W;

    region_e x_region, y_region;
    region_e x_rd_q;
    logic    x_err_q, y_err_q, y_hit_q;
    logic [DATA_W-1:0] reg_q, prog_q;

    logic                           xb_wr;
    logic [0:0]                     xb_rd_en;
    logic [0:0][XR_AW-2:0]          xb_rd_idx;
    logic [0:0][DATA_W-1:0]         xb_rd_data;
    logic                           yb_wr;
    logic [1:0]                     yb_rd_en;
    logic [1:0][YR_AW-2:0]          yb_rd_idx;
    logic [1:0][DATA_W-1:0]         yb_rd_data;
    logic                           x_rd;

    xy_addr_decode #(
        .REG_BYTES(REG_BYTES), .XRAM_BASE(XRAM_BASE), .XRAM_BYTES(XRAM_BYTES),
        .YRAM_BYTES(YRAM_BYTES), .PROG_BASE(PROG_BASE), .IS_Y_PORT(1'b0)
    ) u_xdec (
        .addr(x_addr), .mac_mode(mac_mode), .is_write(x_we),
        .prog_en(prog_win_en), .region(x_region)
    );

    xy_addr_decode #(
        .REG_BYTES(REG_BYTES), .XRAM_BASE(XRAM_BASE), .XRAM_BYTES(XRAM_BYTES),
        .YRAM_BYTES(YRAM_BYTES), .PROG_BASE(PROG_BASE), .IS_Y_PORT(1'b1)
    ) u_ydec (
        .addr(y_addr), .mac_mode(mac_mode), .is_write(1'b0),
        .prog_en(prog_win_en), .region(y_region)
    );

    // Per-bank enables derived from the decoded X and Y regions.
    always_comb begin
        x_rd         = x_req && !x_we;
        xb_wr        = x_req && x_we && (x_region == RG_XRAM);
        xb_rd_en[0]  = x_rd && (x_region == RG_XRAM);
        xb_rd_idx[0] = x_addr[XR_AW-1:1];
        yb_wr        = x_req && x_we && (x_region == RG_YRAM);
        yb_rd_en[0]  = x_rd && (x_region == RG_YRAM);
        yb_rd_idx[0] = x_addr[YR_AW-1:1];
        yb_rd_en[1]  = y_req && (y_region == RG_YRAM);
        yb_rd_idx[1] = y_addr[YR_AW-1:1];
    end

    xy_ram_bank #(.WORDS(XWORDS), .N_RD(1)) u_xbank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(xb_wr), .wr_idx(x_addr[XR_AW-1:1]), .wr_be(x_be), .wr_data(x_wdata),
        .rd_en(xb_rd_en), .rd_idx(xb_rd_idx), .rd_data(xb_rd_data)
    );

    xy_ram_bank #(.WORDS(YWORDS), .N_RD(2)) u_ybank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(yb_wr), .wr_idx(x_addr[YR_AW-1:1]), .wr_be(x_be), .wr_data(x_wdata),
        .rd_en(yb_rd_en), .rd_idx(yb_rd_idx), .rd_data(yb_rd_data)
    );

    // Register-region and program-window passthrough strobes.
    always_comb begin
        reg_req    = x_req && (x_region == RG_REG);
        reg_we     = reg_req && x_we;
        reg_waddr  = x_addr[REG_AW-1:1];
        reg_be     = x_be;
        reg_wdata  = x_wdata;
        prog_req   = x_req && (x_region == RG_PROG);
        prog_waddr = x_addr[PROG_AW-1:1];
    end

    // Response-stage registers: source region, flags and passthrough data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_rd_q  <= RG_NONE;
            x_err_q <= 1'b0;
            y_err_q <= 1'b0;
            y_hit_q <= 1'b0;
            reg_q   <= '0;
            prog_q  <= '0;
        end else begin
            x_rd_q  <= x_rd ? x_region : RG_NONE;
            x_err_q <= x_req && (x_region == RG_NONE);
            y_err_q <= y_req && (y_region == RG_NONE);
            y_hit_q <= yb_rd_en[1];
            if (x_rd && x_region == RG_REG)
                reg_q <= reg_rdata;
            if (x_rd && x_region == RG_PROG)
                prog_q <= prog_rdata;
        end
    end

    // Select the X read data by the region captured in the request cycle.
    always_comb begin
        unique case (x_rd_q)
            RG_REG:  x_rdata = reg_q;
            RG_XRAM: x_rdata = xb_rd_data[0];
            RG_YRAM: x_rdata = yb_rd_data[0];
            RG_PROG: x_rdata = prog_q;
            default: x_rdata = '0;
        endcase
    end

    assign y_rdata = y_hit_q ? yb_rd_data[1] : '0;
    assign x_err   = x_err_q;
    assign y_err   = y_err_q;

    // ---------------- assertions ----------------
    logic x_in_y, y_in_y;
    assign x_in_y = (32'(x_addr) >= 32'(YRAM_BASE)) && (32'(x_addr) < 32'(RAM_END));
    assign y_in_y = (32'(y_addr) >= 32'(YRAM_BASE)) && (32'(y_addr) < 32'(RAM_END));

    p_reg_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> (32'(x_addr) < 32'(REG_BYTES)));

    p_mac_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (x_req && !x_we && mac_mode && x_in_y) |=> (x_err && x_rdata == '0));

    p_y_outside_mac_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (y_req && (!mac_mode || !y_in_y)) |=> (y_err && y_rdata == '0));

    p_xerr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        x_err |-> (x_rdata == '0));

    p_prog_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_win_en |-> !prog_req);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !x_req |=> (!x_err && x_rdata == '0));

    p_yidle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !y_req |=> (!y_err && y_rdata == '0));
endmodule

// File: tb/xy_data_mem_tb.sv
module xy_data_mem_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mac_mode, prog_win_en;
    logic        x_req, x_we;
    logic [15:0] x_addr, x_wdata;
    logic [1:0]  x_be;
    logic [15:0] x_rdata;
    logic        x_err;
    logic        y_req;
    logic [15:0] y_addr, y_rdata;
    logic        y_err;
    logic        reg_req, reg_we;
    logic [9:0]  reg_waddr;
    logic [1:0]  reg_be;
    logic [15:0] reg_wdata, reg_rdata;
    logic        prog_req;
    logic [13:0] prog_waddr;
    logic [15:0] prog_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] xm [256];
    logic [15:0] ym [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Passthrough sources: data is a fixed function of the word address.
    assign reg_rdata  = {6'h31, reg_waddr};
    assign prog_rdata = {2'b10, prog_waddr};

    xy_data_mem dut_i (
        .clk(clk), .rst_n(rst_n), .mac_mode(mac_mode), .prog_win_en(prog_win_en),
        .x_req(x_req), .x_we(x_we), .x_addr(x_addr), .x_be(x_be), .x_wdata(x_wdata),
        .x_rdata(x_rdata), .x_err(x_err),
        .y_req(y_req), .y_addr(y_addr), .y_rdata(y_rdata), .y_err(y_err),
        .reg_req(reg_req), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .prog_req(prog_req), .prog_waddr(prog_waddr), .prog_rdata(prog_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    // Region class computed from the address map in the requirements.
    // 0 none, 1 register, 2 X RAM, 3 Y RAM, 4 program window
    function automatic int cls(input logic [15:0] a, input bit pen);
        if (a < 16'h0800) return 1;
        if (a < 16'h0A00) return 2;
        if (a < 16'h0C00) return 3;
        if (a >= 16'h8000 && pen) return 4;
        return 0;
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] wd,
                                          input logic [1:0] be);
        logic [15:0] r = old;
        if (be[0]) r[7:0]  = wd[7:0];
        if (be[1]) r[15:8] = wd[15:8];
        return r;
    endfunction

    // One cycle: drive, check strobes, update model, check registered outputs.
    task automatic step(input bit xr, input bit we, input logic [15:0] xa, input logic [1:0] be,
                        input logic [15:0] wd, input bit yr, input logic [15:0] ya,
                        input bit mac, input bit pen);
        int          c;
        logic [15:0] ex_d, ey_d;
        logic        ex_e, ey_e, ex_reg, ex_prog;
        string       xt, yt;
        x_req = xr; x_we = we; x_addr = xa; x_be = be; x_wdata = wd;
        y_req = yr; y_addr = ya; mac_mode = mac; prog_win_en = pen;
        c = cls(xa, pen);
        if (c == 3 && mac && !we) c = 0;
        if (c == 4 && we) c = 0;
        case (c)
            1: xt = "R1";
            2: xt = "R2";
            3: xt = mac ? "R4" : "R3";
            4: xt = "R8";
            default: xt = (xa >= 16'h8000) ? "R8" : ((xa >= 16'h0A00 && xa < 16'h0C00) ? "R4" : "R7");
        endcase
        if (!xr) xt = "R9";
        ex_d = 16'h0; ex_e = 1'b0; ex_reg = 1'b0; ex_prog = 1'b0;
        if (xr) begin
            ex_e    = (c == 0);
            ex_reg  = (c == 1);
            ex_prog = (c == 4);
            if (!we) begin
                case (c)
                    1: ex_d = {6'h31, xa[10:1]};
                    2: ex_d = xm[xa[8:1]];
                    3: ex_d = ym[xa[8:1]];
                    4: ex_d = {2'b10, xa[14:1]};
                    default: ex_d = 16'h0;
                endcase
            end
        end
        ey_d = 16'h0; ey_e = 1'b0;
        yt = "R9";
        if (yr) begin
            if (mac && ya >= 16'h0A00 && ya < 16'h0C00) begin
                ey_d = ym[ya[8:1]]; yt = "R5";
            end else begin
                ey_e = 1'b1; yt = "R6";
            end
        end
        #1;
        check({xt, " reg_req"}, {15'h0, reg_req}, {15'h0, ex_reg});
        check({xt, " prog_req"}, {15'h0, prog_req}, {15'h0, ex_prog});
        if (ex_reg) begin
            check("R1 reg_we", {15'h0, reg_we}, {15'h0, we});
            check("R1 reg_waddr", {6'h0, reg_waddr}, {6'h0, xa[10:1]});
        end
        if (ex_prog) check("R8 prog_waddr", {2'h0, prog_waddr}, {2'h0, xa[14:1]});
        if (xr && we && c == 2) xm[xa[8:1]] = merge(xm[xa[8:1]], wd, be);
        if (xr && we && c == 3) ym[xa[8:1]] = merge(ym[xa[8:1]], wd, be);
        @(posedge clk); #1;
        check({xt, " x_rdata"}, x_rdata, ex_d);
        check({xt, " x_err"}, {15'h0, x_err}, {15'h0, ex_e});
        check({yt, " y_rdata"}, y_rdata, ey_d);
        check({yt, " y_err"}, {15'h0, y_err}, {15'h0, ey_e});
    endtask

    function automatic logic [15:0] pick_addr();
        case ($urandom % 6)
            0: return 16'($urandom % 16'h0800);
            1: return 16'h0800 + 16'($urandom % 16'h0200);
            2, 3: return 16'h0A00 + 16'($urandom % 16'h0200);
            4: return 16'h0C00 + 16'($urandom % 16'h7400);
            default: return 16'h8000 | 16'($urandom);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; mac_mode = 0; prog_win_en = 0;
        x_req = 0; x_we = 0; x_addr = 0; x_be = 0; x_wdata = 0; y_req = 0; y_addr = 0;
        repeat (3) @(posedge clk);
        #1;
        // R10: outputs quiet during reset
        check("R10 x_rdata", x_rdata, 16'h0);
        check("R10 y_rdata", y_rdata, 16'h0);
        check("R10 x_err", {15'h0, x_err}, 16'h0);
        check("R10 y_err", {15'h0, y_err}, 16'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R10 x_rdata after release", x_rdata, 16'h0);
        check("R10 y_err after release", {15'h0, y_err}, 16'h0);

        // Fill both banks through the X port in normal mode (R2, R3).
        for (int i = 0; i < 256; i++) begin
            xm[i] = 16'hxxxx; ym[i] = 16'hxxxx;
            step(1, 1, 16'h0800 + 16'(2*i), 2'b11, 16'(i * 37 + 5), 0, 0, 0, 0);
            step(1, 1, 16'h0A00 + 16'(2*i), 2'b11, 16'(i * 91 + 3), 0, 0, 0, 0);
        end

        // R2: byte-enable writes and odd-address aliasing.
        step(1, 1, 16'h0811, 2'b01, 16'hA5C3, 0, 0, 0, 0);
        step(1, 0, 16'h0810, 2'b00, 16'h0, 0, 0, 0, 0);
        step(1, 1, 16'h0810, 2'b10, 16'h7E00, 0, 0, 0, 0);
        step(1, 0, 16'h0811, 2'b00, 16'h0, 0, 0, 0, 0);
        // R3: normal-mode X read of the Y bank.
        step(1, 0, 16'h0BFE, 2'b00, 16'h0, 0, 0, 0, 0);
        // R4: MAC-mode X read of Y bank refused, write still lands.
        step(1, 0, 16'h0A10, 2'b00, 16'h0, 0, 0, 1, 0);
        step(1, 1, 16'h0A10, 2'b11, 16'hBEEF, 1, 16'h0A10, 1, 0);   // R5 old data
        step(0, 0, 16'h0, 2'b00, 16'h0, 1, 16'h0A11, 1, 0);         // R5 new data
        step(1, 0, 16'h0A10, 2'b00, 16'h0, 0, 0, 0, 0);             // R3 readback
        // R5: concurrent X read of X bank and Y read.
        step(1, 0, 16'h09FE, 2'b00, 16'h0, 1, 16'h0A00, 1, 0);
        // R6: Y outside MAC and Y outside its range.
        step(0, 0, 16'h0, 2'b00, 16'h0, 1, 16'h0A20, 0, 0);
        step(0, 0, 16'h0, 2'b00, 16'h0, 1, 16'h09FE, 1, 0);
        step(0, 0, 16'h0, 2'b00, 16'h0, 1, 16'h0C00, 1, 0);
        // R7: unimplemented read and write; write leaves storage untouched.
        step(1, 0, 16'h0C00, 2'b00, 16'h0, 0, 0, 0, 0);
        step(1, 1, 16'h1FFE, 2'b11, 16'h1234, 0, 0, 0, 0);
        step(1, 1, 16'h7FFE, 2'b11, 16'h4321, 0, 0, 1, 1);
        // R8: program window on/off and write refused.
        step(1, 0, 16'h8000, 2'b00, 16'h0, 0, 0, 0, 1);
        step(1, 0, 16'hFFFE, 2'b00, 16'h0, 0, 0, 1, 1);
        step(1, 0, 16'h8002, 2'b00, 16'h0, 0, 0, 0, 0);
        step(1, 1, 16'h8004, 2'b11, 16'h5555, 0, 0, 0, 1);
        // R1: register region write and read.
        step(1, 1, 16'h07FE, 2'b11, 16'hCAFE, 0, 0, 0, 0);
        step(1, 0, 16'h0002, 2'b00, 16'h0, 0, 0, 1, 0);
        // R9: idle cycle after a read.
        step(0, 0, 16'h0, 2'b00, 16'h0, 0, 0, 0, 0);

        // Constrained-random traffic over all regions and modes.
        for (int n = 0; n < 4000; n++) begin
            step($urandom % 5 != 0, $urandom % 3 == 0, pick_addr(), 2'($urandom),
                 16'($urandom), $urandom % 2 == 1, pick_addr(),
                 $urandom % 2 == 1, $urandom % 2 == 1);
        end
        // Verify both banks hold the model contents after random traffic.
        for (int i = 0; i < 256; i++) begin
            step(1, 0, 16'h0800 + 16'(2*i), 2'b00, 16'h0, 1, 16'h0A00 + 16'(2*i), 1, 0);
        end
        summary();
    end
endmodule